// File: doc/BRIEF.md
# Input-Transition-Triggered Power Sequencer

This block runs the power sequence of a memory-and-logic device that sits in standby unless its inputs move. It watches a bus that carries the address and the logic inputs. The bus is synchronised into the clock domain and compared with a registered copy from the previous cycle. When any bit differs and chip select is active, the block leaves standby and raises an array-enable output for a programmable number of settle cycles. On the last of those cycles it pulses a latch strobe, captures the array's output word into a holding register and goes back to standby by itself. Chip select can stay active the whole time.

The holding register drives the device's data outputs. It keeps its value between bus cycles, so the array stays powered down while the bus is quiet. An inactive chip select forces standby at once and stops the block from reacting to input transitions. A transition that arrives while the array is enabled restarts the settle count, so the captured word always belongs to the newest inputs. A wake-event counter lets a test confirm that quiet inputs cause no activity.

Top module: `xact_power_seq`

## Requirements
- R1: After reset, standby is 1, arr_en is 0, latch_stb is 0, held_data is 0 and wake_count is 0.
- R2: With sel_i high, a change of any single bit or any group of bits of in_bus wakes the block. arr_en rises on the third rising edge after the edge at which the new value is first sampled: two synchroniser stages, then one sequencer register.
- R3: Once woken, arr_en stays high for exactly S cycles, where S is settle_cycles and a value of 0 counts as 1. latch_stb is a one-cycle pulse during the last of those cycles.
- R4: held_data takes the value of arr_data at the clock edge that ends the latch_stb cycle. standby and arr_en=0 appear at that same edge.
- R5: While in_bus does not change, arr_en stays 0, held_data keeps its value and wake_count does not change.
- R6: A change of in_bus that is detected while arr_en is high restarts the settle count. arr_en then stays high for a further S cycles with no gap, wake_count still rises by one for the whole access, and held_data ends up with the data for the newest in_bus value.
- R7: While sel_i is low, changes of in_bus are ignored: no wake, no latch, and held_data and wake_count stay unchanged.
- R8: If sel_i falls while arr_en is high, arr_en falls and standby rises on the third rising edge after the edge at which the low level is first sampled. No latch_stb occurs and held_data keeps its old value.
- R9: wake_count rises by exactly one for each move from standby to active, at the same edge where arr_en rises.
- R10: When sel_i returns high and in_bus has not changed since then, the block does not wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high. Low forces standby |
| in_bus | input | IN_W | Address and logic inputs that are watched for transitions |
| settle_cycles | input | SETTLE_W | Array-enable window length in cycles (0 is treated as 1) |
| arr_data | input | DATA_W | Output word of the internal array |
| arr_en | output | 1 | Array power/enable strobe |
| latch_stb | output | 1 | One-cycle capture strobe for the holding register |
| standby | output | 1 | High while the block is in standby |
| held_data | output | DATA_W | Latched output word |
| wake_count | output | CNT_W | Number of wake events, modulo 2^CNT_W |

## Verification
The bench changes inputs on falling edges and counts rising edges from that point. arr_en and wake_count are first due after the third rising edge. latch_stb is due after edge 2+S, and held_data together with the return of standby is due after edge 3+S. For a restart that is detected d edges into the access, these delays grow by d, and a sel_i drop takes effect after the third edge. A monitor samples arr_en and latch_stb on every falling edge and counts how many cycles each is high. Every check runs one time unit after a falling edge, so the window length, the pulse count and the final values are all read at the cycle in which they are due.

// File: rtl/xps_pkg.sv
package xps_pkg;

    typedef enum logic {
        PS_IDLE   = 1'b0,
        PS_ACCESS = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/xps_sync_detect.sv
module xps_sync_detect #(
    parameter int IN_W   = 16,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] bus_raw,
    input  logic            sel_raw,
    output logic [IN_W-1:0] bus_s,
    output logic            sel_s,
    output logic            change
);
    localparam int LAST = STAGES - 1;

    logic [IN_W-1:0] bus_pipe_q [STAGES];
    logic [STAGES-1:0] sel_pipe_q;
    logic [IN_W-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bus_pipe_q[g] <= '0;
                    sel_pipe_q[g] <= 1'b0;
                end else begin
                    bus_pipe_q[g] <= bus_raw;
                    sel_pipe_q[g] <= sel_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bus_pipe_q[g] <= '0;
                    sel_pipe_q[g] <= 1'b0;
                end else begin
                    bus_pipe_q[g] <= bus_pipe_q[g-1];
                    sel_pipe_q[g] <= sel_pipe_q[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= bus_pipe_q[LAST];
    end

    assign bus_s  = bus_pipe_q[LAST];
    assign sel_s  = sel_pipe_q[LAST];
    assign change = |(bus_pipe_q[LAST] ^ prev_q);

endmodule

// File: rtl/xps_seq_fsm.sv
module xps_seq_fsm
    import xps_pkg::*;
#(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                change,
    input  logic                sel_s,
    input  logic [SETTLE_W-1:0] settle,
    output logic                arr_en,
    output logic                latch_stb,
    output logic                standby,
    output logic                wake_pulse
);
    typedef struct packed {
        pwr_state_e          st;
        logic [SETTLE_W-1:0] cnt;
        logic                en;
        logic                last;
    } seq_regs_t;

    seq_regs_t           seq_d, seq_q;
    logic [SETTLE_W-1:0] settle_eff;
    logic [SETTLE_W-1:0] cnt_inc;
    logic                wake_d;

    assign settle_eff = (settle == '0) ? SETTLE_W'(1) : settle;
    assign cnt_inc    = seq_q.cnt + SETTLE_W'(1);

    always_comb begin
        seq_d  = seq_q;
        wake_d = 1'b0;
        if (!sel_s) begin
            seq_d.st   = PS_IDLE;
            seq_d.cnt  = '0;
            seq_d.en   = 1'b0;
            seq_d.last = 1'b0;
        end else begin
            unique case (seq_q.st)
                PS_IDLE: begin
                    if (change) begin
                        seq_d.st   = PS_ACCESS;
                        seq_d.cnt  = SETTLE_W'(1);
                        seq_d.en   = 1'b1;
                        seq_d.last = (settle_eff == SETTLE_W'(1));
                        wake_d     = 1'b1;
                    end
                end
                PS_ACCESS: begin
                    if (change) begin
                        seq_d.cnt  = SETTLE_W'(1);
                        seq_d.last = (settle_eff == SETTLE_W'(1));
                    end else if (seq_q.last) begin
                        seq_d.st   = PS_IDLE;
                        seq_d.cnt  = '0;
                        seq_d.en   = 1'b0;
                        seq_d.last = 1'b0;
                    end else begin
                        seq_d.cnt  = cnt_inc;
                        seq_d.last = (cnt_inc >= settle_eff);
                    end
                end
                default: seq_d = seq_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= PS_IDLE;
            seq_q.cnt  <= '0;
            seq_q.en   <= 1'b0;
            seq_q.last <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign arr_en     = seq_q.en;
    assign standby    = (seq_q.st == PS_IDLE);
    assign latch_stb  = seq_q.last & seq_q.en & sel_s & ~change;
    assign wake_pulse = wake_d;

    // R3: capture strobe only inside an enabled window
    a_r3_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> arr_en);

    // R3: strobe is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> !latch_stb);

    // R4: standby follows the capture
    a_r4_standby_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> (standby && !arr_en));

    // R7: inactive select forces standby
    a_r7_sel_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> (standby && !arr_en));

    // R2: array only wakes because of a detected transition
    a_r2_wake_from_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_en) |-> $past(change));

endmodule

// File: rtl/xps_hold_reg.sv
module xps_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap) hold_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign dout = hold_q;

    // R5: without a capture strobe the latched word never moves
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(dout));

endmodule

// File: rtl/xps_event_counter.sv
module xps_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/xact_power_seq.sv
module xact_power_seq #(
    parameter int IN_W        = 16,
    parameter int DATA_W      = 8,
    parameter int SETTLE_W    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_i,
    input  logic [IN_W-1:0]     in_bus,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [DATA_W-1:0]   arr_data,
    output logic                arr_en,
    output logic                latch_stb,
    output logic                standby,
    output logic [DATA_W-1:0]   held_data,
    output logic [CNT_W-1:0]    wake_count
);
    logic [IN_W-1:0] bus_s;
    logic            sel_s;
    logic            change;
    logic            wake_pulse;

    xps_sync_detect #(
        .IN_W   (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_raw (in_bus),
        .sel_raw (sel_i),
        .bus_s   (bus_s),
        .sel_s   (sel_s),
        .change  (change)
    );

    xps_seq_fsm #(
        .SETTLE_W (SETTLE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .change     (change),
        .sel_s      (sel_s),
        .settle     (settle_cycles),
        .arr_en     (arr_en),
        .latch_stb  (latch_stb),
        .standby    (standby),
        .wake_pulse (wake_pulse)
    );

    xps_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (latch_stb),
        .din   (arr_data),
        .dout  (held_data)
    );

    xps_event_counter #(
        .CNT_W (CNT_W)
    ) u_wakes (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wake_pulse),
        .count (wake_count)
    );

    // R9: every rise of the enable is counted exactly once
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_en) |-> ((wake_count - $past(wake_count)) == CNT_W'(1)));

    // R5: counter only moves together with a rising enable
    a_r5_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(arr_en) |-> $stable(wake_count));

endmodule

// File: tb/xact_power_seq_tb.sv
`timescale 1ns/1ps
module xact_power_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b1;
    logic [15:0] in_bus = '0;
    logic [3:0]  settle_cycles = 4'd3;
    logic [7:0]  arr_data;
    logic        arr_en, latch_stb, standby;
    logic [7:0]  held_data;
    logic [15:0] wake_count;

    int n_checks = 0;
    int n_fail   = 0;
    int en_cnt   = 0;
    int stb_cnt  = 0;
    logic [15:0] exp_wakes = '0;
    logic [7:0]  exp_held  = '0;

    always #4 clk = ~clk;

    function automatic logic [7:0] array_word(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic int eff(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    assign arr_data = arr_en ? array_word(in_bus) : 8'h00;

    xact_power_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .in_bus(in_bus),
        .settle_cycles(settle_cycles), .arr_data(arr_data), .arr_en(arr_en),
        .latch_stb(latch_stb), .standby(standby), .held_data(held_data),
        .wake_count(wake_count)
    );

    always @(negedge clk) begin
        if (arr_en)    en_cnt++;
        if (latch_stb) stb_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        en_cnt  = 0;
        stb_cnt = 0;
    endtask

    // full access: drive at a falling edge, check after edge 3+S
    task automatic access(input logic [15:0] v, input int s, input string tag);
        clear_mon();
        settle_cycles = s[3:0];
        in_bus = v;
        wait_neg(2);
        check(arr_en == 1'b0, {tag, " R2 not early"}, arr_en, 0);
        wait_neg(1);
        check(arr_en == 1'b1, {tag, " R2 wake edge"}, arr_en, 1);
        exp_wakes++;
        check(wake_count == exp_wakes, {tag, " R9 count"}, wake_count, exp_wakes);
        wait_neg(eff(s));
        exp_held = array_word(v);
        check(en_cnt == eff(s), {tag, " R3 window"}, en_cnt, eff(s));
        check(stb_cnt == 1, {tag, " R3 pulse"}, stb_cnt, 1);
        check(held_data == exp_held, {tag, " R4 data"}, held_data, exp_held);
        check(standby == 1'b1 && arr_en == 1'b0, {tag, " R4 standby"}, standby, 1);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int s, d;
        void'($urandom(32'd20240611));
        wait_neg(3);
        // R1 reset state
        check(standby == 1 && arr_en == 0 && latch_stb == 0, "R1 ctrl", {standby, arr_en, latch_stb}, 3'b100);
        check(held_data == 0 && wake_count == 0, "R1 data", held_data, 0);
        @(negedge clk); rst_n = 1'b1;
        wait_neg(4);
        check(standby == 1 && wake_count == 0, "R1 after release", wake_count, 0);

        // directed accesses, S = 0, 1, 15
        access(16'h1234, 0, "d0");
        access(16'h8000, 1, "d1");
        access(16'h0001, 15, "d15");

        // R5 quiet bus
        clear_mon();
        wait_neg(60);
        check(en_cnt == 0, "R5 no enable", en_cnt, 0);
        check(wake_count == exp_wakes && held_data == exp_held, "R5 state held", wake_count, exp_wakes);

        // R6 restart during window
        for (int k = 0; k < 6; k++) begin
            s = 2 + ($urandom % 13);
            d = 1 + ($urandom % s);
            clear_mon();
            settle_cycles = s[3:0];
            in_bus = in_bus ^ 16'h0F0F;
            wait_neg(d);
            v = in_bus ^ (16'h1 << ($urandom % 16));
            in_bus = v;
            wait_neg(d + s + 3 - d);
            exp_wakes++;
            exp_held = array_word(v);
            check(en_cnt == d + s, "R6 stretched window", en_cnt, d + s);
            check(stb_cnt == 1 && held_data == exp_held, "R6 newest data", held_data, exp_held);
            check(wake_count == exp_wakes && standby, "R6 one wake", wake_count, exp_wakes);
        end

        // R7 sel low ignores transitions
        @(negedge clk); sel_i = 1'b0;
        wait_neg(4);
        clear_mon();
        in_bus = in_bus ^ 16'hFFFF;
        wait_neg(20);
        check(en_cnt == 0 && stb_cnt == 0, "R7 no wake", en_cnt, 0);
        check(held_data == exp_held && wake_count == exp_wakes, "R7 state kept", held_data, exp_held);
        // R10 sel back high, no new change
        @(negedge clk); sel_i = 1'b1;
        clear_mon();
        wait_neg(20);
        check(en_cnt == 0 && wake_count == exp_wakes, "R10 no wake on select", en_cnt, 0);

        // R8 abort by select drop
        clear_mon();
        settle_cycles = 4'd10;
        in_bus = in_bus ^ 16'h00F0;
        wait_neg(4);
        exp_wakes++;
        check(arr_en == 1'b1, "R8 woke", arr_en, 1);
        sel_i = 1'b0;
        wait_neg(2);
        check(arr_en == 1'b1, "R8 not early", arr_en, 1);
        wait_neg(1);
        check(arr_en == 1'b0 && standby == 1'b1, "R8 forced standby", arr_en, 0);
        check(stb_cnt == 0 && held_data == exp_held, "R8 no capture", held_data, exp_held);
        check(wake_count == exp_wakes, "R9 abort counted", wake_count, exp_wakes);
        @(negedge clk); sel_i = 1'b1;
        wait_neg(8);

        // random accesses, single-bit and multi-bit changes
        for (int k = 0; k < 30; k++) begin
            s = $urandom % 16;
            if ($urandom % 2) v = in_bus ^ (16'h1 << ($urandom % 16));
            else v = 16'($urandom);
            if (v == in_bus) v = ~in_bus;
            access(v, s, "rnd");
            wait_neg($urandom % 4);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule